// File: doc/BRIEF.md
# Four-Decade Display Counter

This block is a four-digit decimal up-counter with a built-in display scanner. Each falling edge on the count input adds one to the count, which runs from 0000 to 9999 and then wraps. A holding register keeps a copy of the count. While the latch-enable input is high, the copy follows the counter. When latch-enable goes low, the copy freezes, so a reading can be shown while counting goes on.

A display-select input chooses what is shown: the live count or the held copy. The block scans the four digits itself, using a prescaler driven by the system clock. At any time one digit-enable output is high, and the seven-segment bus carries the pattern for that digit. A carry output rises when the count reaches 6000 and falls when the count wraps to 0000, so counters can be chained.

The count input is synchronised to the system clock. The whole block runs in one clock domain with one asynchronous active-high reset.

Top module: `qdc_counter_display`

## Requirements
- R1: While `rst` is high, the count and the held copy are 0000, `carry_out` is low, and `digit_en` is 4'b0001. All three take effect at once, without waiting for a clock edge.
- R2: The count advances by exactly one for each high-to-low transition of `count_in`. A rising edge, or a level held for any length of time, leaves the count unchanged.
- R3: Each decade holds a BCD value 0 to 9. When a decade steps from 9 to 0, the next decade up advances by one, for example 0009 to 0010 and 0099 to 0100.
- R4: One step from 9999 gives 0000.
- R5: `carry_out` goes high in the same cycle the count becomes 6000. It stays high through 9999 and goes low in the same cycle the count wraps to 0000.
- R6: While `latch_en` is low, the held copy keeps its value even as the count advances.
- R7: While `latch_en` is high, the held copy takes the count one cycle later.
- R8: With `disp_live` high the display shows the count; with it low the display shows the held copy.
- R9: Exactly one `digit_en` bit is high at a time. The active bit moves bit 0, 1, 2, 3 and back to 0, and stays on each digit for SCAN_DIV clock cycles. Bit k selects decade k, where decade 0 is the least significant.
- R10: `seg` is active high, with bit 0 as segment a through bit 6 as segment g. The digits 0 to 9 are coded 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F in hexadecimal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| count_in | input | 1 | Count pulse input; a falling edge advances the count |
| latch_en | input | 1 | High: the held copy follows the count; low: it holds |
| disp_live | input | 1 | High: display the live count; low: display the held copy |
| digit_en | output | NUM_DIGITS | One-hot digit select for the scan |
| seg | output | 7 | Segment pattern a..g for the selected digit |
| carry_out | output | 1 | Cascade output: high from 6000 until the wrap to 0000 |

## Verification
The count input is first held high for many cycles and then released. This separates falling-edge counting from level or rising-edge counting. Single steps then walk the low decade through every value, which checks each segment code and the first decade carry. Long pulse runs cross 0099, 5999/6000 and 9999/0000, which separate the BCD carry, the cascade output's set and clear points and the wrap. Counting with latch-enable low, then reading the display both ways, separates the held copy from the live count. A reset in the middle of a count shows that it clears at once.

// File: rtl/qdc_pkg.sv
package qdc_pkg;

  typedef logic [3:0] bcd_t;

  typedef struct packed {
    bcd_t digit;
    logic carry;
  } dec_step_t;

  // One decade step: add the incoming carry, wrap 9 -> 0 with carry out.
  function automatic dec_step_t dec_step(bcd_t d, logic ci);
    dec_step_t r;
    r.digit = d;
    r.carry = 1'b0;
    if (ci) begin
      if (d >= 4'd9) begin
        r.digit = 4'd0;
        r.carry = 1'b1;
      end else begin
        r.digit = d + 4'd1;
      end
    end
    return r;
  endfunction

  // Active-high segments, bit 0 = a ... bit 6 = g.
  function automatic logic [6:0] seg_of(bcd_t d);
    logic [6:0] s;
    case (d)
      4'd0:    s = 7'h3F;
      4'd1:    s = 7'h06;
      4'd2:    s = 7'h5B;
      4'd3:    s = 7'h4F;
      4'd4:    s = 7'h66;
      4'd5:    s = 7'h6D;
      4'd6:    s = 7'h7D;
      4'd7:    s = 7'h07;
      4'd8:    s = 7'h7F;
      4'd9:    s = 7'h6F;
      default: s = 7'h00;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/qdc_edge_sync.sv
module qdc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic fall
);
  // pipe[STAGES-1] is the synchronised level, pipe[STAGES] its previous value.
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-1:0], din};
  end

  assign fall = pipe[STAGES] & ~pipe[STAGES-1];
endmodule

// File: rtl/qdc_bcd_chain.sv
module qdc_bcd_chain
  import qdc_pkg::*;
#(
  parameter int NUM_DIGITS = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    step,
  output logic [4*NUM_DIGITS-1:0] value,
  output logic [4*NUM_DIGITS-1:0] next_value,
  output logic                    wrap
);
  localparam int W = 4 * NUM_DIGITS;

  logic [NUM_DIGITS:0] ripple;
  assign ripple[0] = step;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_dec
    dec_step_t s;
    assign s                   = dec_step(value[4*g +: 4], ripple[g]);
    assign next_value[4*g +: 4] = s.digit;
    assign ripple[g+1]         = s.carry;
  end

  assign wrap = ripple[NUM_DIGITS];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) value <= {W{1'b0}};
    else     value <= next_value;
  end
endmodule

// File: rtl/qdc_hold_latch.sv
module qdc_hold_latch #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         le,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst)     q <= '0;
    else if (le) q <= d;
  end
endmodule

// File: rtl/qdc_scan.sv
module qdc_scan #(
  parameter int NUM_DIGITS = 4,
  parameter int SCAN_DIV   = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic [(NUM_DIGITS>1 ? $clog2(NUM_DIGITS) : 1)-1:0] idx,
  output logic [NUM_DIGITS-1:0] en
);
  localparam int IW = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;
  localparam int PW = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;

  logic [PW-1:0] pre;
  logic          tick;

  assign tick = (pre == PW'(SCAN_DIV - 1));

  always_ff @(posedge clk or posedge rst) begin
    if (rst)       pre <= '0;
    else if (tick) pre <= '0;
    else           pre <= pre + 1'b1;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) idx <= '0;
    else if (tick) begin
      if (idx == IW'(NUM_DIGITS - 1)) idx <= '0;
      else                            idx <= idx + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_en
    assign en[g] = (idx == IW'(g));
  end
endmodule

// File: rtl/qdc_counter_display.sv
module qdc_counter_display
  import qdc_pkg::*;
#(
  parameter int NUM_DIGITS  = 4,
  parameter int SCAN_DIV    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int CARRY_MSD   = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  count_in,
  input  logic                  latch_en,
  input  logic                  disp_live,
  output logic [NUM_DIGITS-1:0] digit_en,
  output logic [6:0]            seg,
  output logic                  carry_out
);
  localparam int W  = 4 * NUM_DIGITS;
  localparam int IW = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;
  localparam logic [W-1:0] CARRY_PAT = W'(CARRY_MSD) << (4 * (NUM_DIGITS - 1));

  // Named internal events, also watched by the bound checker.
  logic          cnt_step;
  logic          wrap;
  logic          carry_hit;
  logic [W-1:0]  live_val;
  logic [W-1:0]  next_val;
  logic [W-1:0]  latch_val;
  logic [W-1:0]  shown;
  logic [IW-1:0] scan_idx;

  qdc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (count_in),
    .fall (cnt_step)
  );

  qdc_bcd_chain #(.NUM_DIGITS(NUM_DIGITS)) u_chain (
    .clk        (clk),
    .rst        (rst),
    .step       (cnt_step),
    .value      (live_val),
    .next_value (next_val),
    .wrap       (wrap)
  );

  qdc_hold_latch #(.W(W)) u_hold (
    .clk (clk),
    .rst (rst),
    .le  (latch_en),
    .d   (live_val),
    .q   (latch_val)
  );

  qdc_scan #(.NUM_DIGITS(NUM_DIGITS), .SCAN_DIV(SCAN_DIV)) u_scan (
    .clk (clk),
    .rst (rst),
    .idx (scan_idx),
    .en  (digit_en)
  );

  assign carry_hit = (next_val == CARRY_PAT);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) carry_out <= 1'b0;
    else if (cnt_step) begin
      if (wrap)           carry_out <= 1'b0;
      else if (carry_hit) carry_out <= 1'b1;
    end
  end

  assign shown = disp_live ? live_val : latch_val;
  assign seg   = seg_of(shown[4*int'(scan_idx) +: 4]);
endmodule

// File: rtl/qdc_counter_display_chk.sv
module qdc_counter_display_chk #(
  parameter int NUM_DIGITS = 4,
  parameter int SCAN_DIV   = 4,
  parameter int CARRY_MSD  = 6
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    latch_en,
  input logic                    cnt_step,
  input logic [NUM_DIGITS-1:0]   digit_en,
  input logic                    carry_out,
  input logic [4*NUM_DIGITS-1:0] live,
  input logic [4*NUM_DIGITS-1:0] latched
);
  localparam int W = 4 * NUM_DIGITS;
  localparam logic [W-1:0] SET_PAT  = W'(CARRY_MSD) << (4 * (NUM_DIGITS - 1));
  localparam logic [W-1:0] ALL_NINE = {NUM_DIGITS{4'h9}};

  logic [NUM_DIGITS-1:0] prev_en;
  int                    held;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      prev_en <= NUM_DIGITS'(1);
      held    <= 0;
    end else begin
      prev_en <= digit_en;
      held    <= (digit_en != prev_en) ? 1 : held + 1;
    end
  end

  assert_scan_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot(digit_en));

  assert_scan_order_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(digit_en) |-> digit_en == {$past(digit_en[NUM_DIGITS-2:0]), $past(digit_en[NUM_DIGITS-1])});

  assert_scan_dwell_R9: assert property (@(posedge clk) disable iff (rst)
    (digit_en != prev_en) |-> held == SCAN_DIV);

  assert_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !cnt_step |=> $stable(live));

  assert_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (cnt_step && live == ALL_NINE) |=> live == '0);

  assert_carry_set_R5: assert property (@(posedge clk) disable iff (rst)
    (live == SET_PAT) |-> carry_out);

  assert_carry_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (live == '0) |-> !carry_out);

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !latch_en |=> $stable(latched));

  assert_follow_R7: assert property (@(posedge clk) disable iff (rst)
    latch_en |=> latched == $past(live));

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_rng
    assert_decade_range_R3: assert property (@(posedge clk) disable iff (rst)
      live[4*g +: 4] <= 4'd9);
  end
endmodule

bind qdc_counter_display qdc_counter_display_chk #(
  .NUM_DIGITS (NUM_DIGITS),
  .SCAN_DIV   (SCAN_DIV),
  .CARRY_MSD  (CARRY_MSD)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .latch_en  (latch_en),
  .cnt_step  (cnt_step),
  .digit_en  (digit_en),
  .carry_out (carry_out),
  .live      (live_val),
  .latched   (latch_val)
);

// File: tb/qdc_counter_display_bench.sv
module qdc_counter_display_bench;
  localparam int SCAN_DIV = 4;

  logic       clk = 1'b0;
  logic       rst;
  logic       count_in;
  logic       latch_en;
  logic       disp_live;
  logic [3:0] digit_en;
  logic [6:0] seg;
  logic       carry_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  qdc_counter_display #(.SCAN_DIV(SCAN_DIV)) u_qdc_counter_display (
    .clk       (clk),
    .rst       (rst),
    .count_in  (count_in),
    .latch_en  (latch_en),
    .disp_live (disp_live),
    .digit_en  (digit_en),
    .seg       (seg),
    .carry_out (carry_out)
  );

  function automatic logic [3:0] seg_digit(logic [6:0] s);
    case (s)
      7'b0111111: return 4'd0;
      7'b0000110: return 4'd1;
      7'b1011011: return 4'd2;
      7'b1001111: return 4'd3;
      7'b1100110: return 4'd4;
      7'b1101101: return 4'd5;
      7'b1111101: return 4'd6;
      7'b0000111: return 4'd7;
      7'b1111111: return 4'd8;
      7'b1101111: return 4'd9;
      default:    return 4'hF;
    endcase
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver side: push an expected display value and wait for the monitor.
  task automatic expect_disp(logic [15:0] v, string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic pulse(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) count_in = 1'b1;
      repeat (2) @(negedge clk);
      count_in = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  // Monitor: read one full scan per expected item.
  initial begin
    logic [15:0] got;
    forever begin
      @(negedge clk);
      if (exp_q.size() != 0) begin
        for (int k = 0; k < 4; k++) begin
          while (digit_en != (4'b0001 << k)) @(negedge clk);
          got[4*k +: 4] = seg_digit(seg);
        end
        check(got == exp_q[0], tag_q[0], 32'(got), 32'(exp_q[0]));
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [3:0] prev;
    int run;
    rst = 1'b1; count_in = 1'b0; latch_en = 1'b1; disp_live = 1'b1;
    repeat (3) @(negedge clk);
    check(digit_en == 4'b0001, "R1 digit_en", 32'(digit_en), 32'h1);
    check(carry_out == 1'b0, "R1 carry", 32'(carry_out), 32'h0);
    rst = 1'b0;
    expect_disp(16'h0000, "R1 count");

    // R2: a long high level and its rising edge do not count; the fall does.
    count_in = 1'b1;
    repeat (12) @(negedge clk);
    expect_disp(16'h0000, "R2 level");
    count_in = 1'b0;
    repeat (6) @(negedge clk);
    expect_disp(16'h0001, "R2 fall");

    // R10: every digit code on the low decade.
    for (int d = 2; d <= 9; d++) begin
      pulse(1);
      expect_disp(16'(d), "R10 code");
    end
    pulse(1);
    expect_disp(16'h0010, "R3 first carry");
    pulse(89);
    expect_disp(16'h0099, "R3 run");
    pulse(1);
    expect_disp(16'h0100, "R3 double carry");

    // R6 / R8: hold while counting.
    @(negedge clk) latch_en = 1'b0;
    pulse(5);
    disp_live = 1'b0;
    expect_disp(16'h0100, "R6 held");
    disp_live = 1'b1;
    expect_disp(16'h0105, "R8 live");

    // R7: transparent again.
    latch_en = 1'b1;
    repeat (2) @(negedge clk);
    disp_live = 1'b0;
    expect_disp(16'h0105, "R7 follow");
    disp_live = 1'b1;

    // R5 / R4: cascade output around 6000 and the wrap.
    pulse(5894);
    expect_disp(16'h5999, "R5 5999");
    check(carry_out == 1'b0, "R5 low at 5999", 32'(carry_out), 32'h0);
    pulse(1);
    expect_disp(16'h6000, "R5 6000");
    check(carry_out == 1'b1, "R5 high at 6000", 32'(carry_out), 32'h1);
    pulse(1);
    check(carry_out == 1'b1, "R5 high at 6001", 32'(carry_out), 32'h1);
    pulse(3998);
    expect_disp(16'h9999, "R4 9999");
    check(carry_out == 1'b1, "R5 high at 9999", 32'(carry_out), 32'h1);
    pulse(1);
    expect_disp(16'h0000, "R4 wrap");
    check(carry_out == 1'b0, "R5 low at wrap", 32'(carry_out), 32'h0);

    // R9: scan order and dwell.
    @(negedge clk);
    prev = digit_en;
    while (digit_en == prev) @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      prev = digit_en;
      run  = 0;
      while (digit_en == prev) begin
        run++;
        @(negedge clk);
      end
      check(run == SCAN_DIV, "R9 dwell", 32'(run), 32'(SCAN_DIV));
      check(digit_en == {prev[2:0], prev[3]}, "R9 order", 32'(digit_en), 32'({prev[2:0], prev[3]}));
    end

    // R1: asynchronous reset in mid count.
    pulse(6000);
    check(carry_out == 1'b1, "R5 before reset", 32'(carry_out), 32'h1);
    @(negedge clk);
    #1 rst = 1'b1;
    #1;
    check(carry_out == 1'b0, "R1 async carry", 32'(carry_out), 32'h0);
    check(digit_en == 4'b0001, "R1 async scan", 32'(digit_en), 32'h1);
    @(negedge clk) rst = 1'b0;
    expect_disp(16'h0000, "R1 live cleared");
    latch_en  = 1'b0;
    disp_live = 1'b0;
    expect_disp(16'h0000, "R1 held cleared");

    summary();
  end
endmodule